// File: doc/BRIEF.md
# Burst Framer with Idle Padding

The block turns an internal packet stream into a stream of 16-bit words, each with a flag that marks it as payload or control. A packet reaches the input as two-byte beats with a channel number, a last-beat flag and an odd-length flag. The block frames each packet with a start control word that carries the channel and an end control word that gives the number of valid bytes in the last word. After the end of a packet it pads with IDLE control words to a fixed byte granularity. Each control word carries a 4-bit parity over the words since the previous control word.

A mode input selects the packing. In lite mode each packet's payload plus padding fills a multiple of LITE_BYTES bytes (16 by default, 8 for the narrow variant). In full mode the granularity is 4 bytes. The end of one packet and the start of the next can share one control word, or can sit in neighbouring control words. In both modes two start words are never closer than SOP_GAP output words, and the block emits IDLE words to keep that distance. The output valid is high whenever the block is out of reset. With nothing to send, the block sends IDLE words. If the input runs dry in the middle of a packet, the block sends IDLE words and then a continuation control word before the payload resumes.

Top module: `burst_framer`

## Requirements
- R1: A payload word has out_ctl=0 and carries exactly one accepted input beat: the earlier byte of the packet in bits [15:8] and the later byte in bits [7:0]. Bytes leave in input order, and in_ready is high only in a cycle that emits a payload word.
- R2: Every control word has out_ctl=1 and bit 15 set. Bit 12 marks a start-of-packet word. Bits [11:4] hold the packet's channel on start and continuation words and 0 on all others.
- R3: Two start-of-packet control words are always at least SOP_GAP (8) accepted output words apart.
- R4: In lite mode an end word is never merged with a start word. Between a packet's end word and the next start word at least P IDLE words appear, where P makes the packet's payload word count plus P a multiple of LITE_BYTES/2.
- R5: In full mode an end word may also carry the next packet's start (bit 12 set together with an end status). This happens only when the ending packet has an even number of payload words, which is 4-byte alignment.
- R6: Bits [14:13] of a control word are 2'b10 for an end with two valid bytes in the last word, 2'b11 for an end with one valid byte (odd length, valid byte in [15:8]), and 2'b00 when the word ends no packet.
- R7: Bits [3:0] of a control word equal the XOR of the four nibbles of X. X is the XOR of all payload words since the previous control word and of the control word itself with its bits [3:0] set to 4'hF.
- R8: With no input pending between packets, the block emits IDLE words. An IDLE word that directly follows a control word is 16'h8007.
- R9: If in_valid drops inside a packet, the block emits IDLE words. When data returns, it emits one continuation control word (end status 00, bit 12 clear, channel in [11:4]) before the next payload word.
- R10: While out_ready is low, in_ready is low and the framing state does not advance.
- R11: While rst_n is low, out_valid is low. After release, out_valid rises within two clock edges and the first word is the IDLE word 16'h8007.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_full | input | 1 | 1 selects full (4-byte) packing, 0 selects lite packing |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted this cycle |
| in_data | input | 16 | Two payload bytes, earlier byte in [15:8] |
| in_last | input | 1 | Beat is the last of its packet |
| in_odd | input | 1 | Last beat holds one valid byte (in [15:8]) |
| in_chan | input | 8 | Channel of the packet, read at packet start |
| out_valid | output | 1 | Output word valid (high out of reset) |
| out_ready | input | 1 | Downstream takes the output word |
| out_word | output | 16 | Payload or control word |
| out_ctl | output | 1 | 1 marks a control word |

## Verification
The hardest case to reach is a merged end-and-start control word in full mode. It needs an even payload word count, the next packet waiting in the very cycle the end word goes out, and at least eight words since the previous start. The stimulus table therefore feeds a long even-length full-mode packet directly followed by another, so all three conditions meet. Short full-mode packets placed next to it produce the opposite case, where spacing forces the end word and the start word apart. Lite/full switches are made only after the previous packet's padding has drained, so that each padding check applies to one mode.

// File: rtl/bf_pkg.sv
package bf_pkg;

  typedef enum logic [1:0] {
    EOPS_NONE  = 2'b00,
    EOPS_ABORT = 2'b01,
    EOPS_TWO   = 2'b10,
    EOPS_ONE   = 2'b11
  } eop_status_t;

  typedef enum logic [2:0] {
    ST_HEAD,
    ST_DATA,
    ST_PAUSE,
    ST_EOP,
    ST_PAD
  } fr_state_t;

  // Fold a 16-bit XOR sum into a 4-bit parity nibble.
  function automatic logic [3:0] nib_fold(input logic [15:0] x);
    return x[15:12] ^ x[11:8] ^ x[7:4] ^ x[3:0];
  endfunction

endpackage

// File: rtl/bf_rst_sync.sv
module bf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/bf_sop_gap.sv
module bf_sop_gap #(
  parameter int SOP_GAP = 8,
  parameter int GW      = $clog2(SOP_GAP)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic sop_beat,
  output logic gap_ok
);
  localparam logic [GW-1:0] SAT = GW'(SOP_GAP - 1);

  logic [GW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (sop_beat)                cnt_d = '0;
    else if (beat && cnt_q != SAT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= SAT;
    else        cnt_q <= cnt_d;
  end

  assign gap_ok = (cnt_q == SAT);

  // R3: a start word is only issued once the spacing window has elapsed
  p_sop_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sop_beat |-> gap_ok);
  // R3: after a start word the window is closed on the next cycle
  p_gap_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sop_beat |=> !gap_ok);
endmodule

// File: rtl/bf_pad_track.sv
module bf_pad_track #(
  parameter int LITE_WORDS = 8,
  parameter int PW         = $clog2(LITE_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_beat,
  input  logic          sop_beat,
  input  logic          mode_full,
  output logic [PW-1:0] pad_req
);
  logic [PW-1:0] wcnt_q, wcnt_d;
  logic [PW-1:0] lite_pad, full_pad;

  always_comb begin
    wcnt_d = wcnt_q;
    if (sop_beat)       wcnt_d = '0;
    else if (data_beat) wcnt_d = wcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt_q <= '0;
    else        wcnt_q <= wcnt_d;
  end

  // Words missing to the next lite boundary (power-of-two group).
  assign lite_pad = PW'(0) - wcnt_q;

  generate
    if (PW > 1) begin : g_full_wide
      assign full_pad = {{(PW-1){1'b0}}, wcnt_q[0]};
    end else begin : g_full_narrow
      assign full_pad = wcnt_q[0];
    end
  endgenerate

  assign pad_req = mode_full ? full_pad : lite_pad;

  // R5: full-mode padding never exceeds one word
  p_full_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_full |-> (pad_req <= PW'(1)));
endmodule

// File: rtl/bf_dip_gen.sv
module bf_dip_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        beat,
  input  logic        is_ctl,
  input  logic [15:0] data_word,
  input  logic [11:0] ctl_body,
  output logic [3:0]  dip
);
  import bf_pkg::*;

  logic [15:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (beat) acc_d = is_ctl ? 16'h0000 : (acc_q ^ data_word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign dip = nib_fold(acc_q ^ {ctl_body, 4'hF});

  // R7: the running sum is empty right after any control word
  p_acc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && is_ctl) |=> (acc_q == 16'h0000));
endmodule

// File: rtl/burst_framer.sv
module burst_framer #(
  parameter int LITE_BYTES = 16,
  parameter int SOP_GAP    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_full,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_data,
  input  logic        in_last,
  input  logic        in_odd,
  input  logic [7:0]  in_chan,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_word,
  output logic        out_ctl
);
  import bf_pkg::*;

  localparam int LITE_WORDS = LITE_BYTES / 2;
  localparam int PW         = $clog2(LITE_WORDS);

  logic run_n;
  logic beat, gap_ok, sop_ok;
  logic [PW-1:0] pad_req;
  logic [3:0]    dip;

  fr_state_t   st_q, st_d;
  logic [PW-1:0] pad_q, pad_d;
  logic        odd_q, odd_d;
  logic [7:0]  chan_q, chan_d;

  logic        c_ctl, c_sop, c_take;
  eop_status_t c_eops;
  logic [7:0]  c_addr;
  logic [11:0] ctl_body;

  bf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(run_n));

  assign out_valid = run_n;
  assign beat      = out_valid & out_ready;
  assign sop_ok    = in_valid & gap_ok;

  // Next-state and output decode
  always_comb begin
    st_d   = st_q;
    pad_d  = pad_q;
    odd_d  = odd_q;
    chan_d = chan_q;
    c_ctl  = 1'b1;
    c_eops = EOPS_NONE;
    c_sop  = 1'b0;
    c_addr = '0;
    c_take = 1'b0;
    unique case (st_q)
      ST_HEAD: begin
        if (sop_ok) begin
          c_sop = 1'b1; c_addr = in_chan; chan_d = in_chan; st_d = ST_DATA;
        end
      end
      ST_DATA: begin
        if (in_valid) begin
          c_ctl  = 1'b0;
          c_take = 1'b1;
          if (in_last) begin
            st_d  = ST_EOP;
            odd_d = in_odd;
          end
        end else begin
          st_d = ST_PAUSE;
        end
      end
      ST_PAUSE: begin
        if (in_valid) begin
          c_addr = chan_q;
          st_d   = ST_DATA;
        end
      end
      ST_EOP: begin
        c_eops = odd_q ? EOPS_ONE : EOPS_TWO;
        if (mode_full && pad_req == '0 && sop_ok) begin
          c_sop = 1'b1; c_addr = in_chan; chan_d = in_chan; st_d = ST_DATA;
        end else if (pad_req != '0) begin
          st_d  = ST_PAD;
          pad_d = pad_req;
        end else begin
          st_d = ST_HEAD;
        end
      end
      ST_PAD: begin
        if (mode_full && sop_ok) begin
          c_sop = 1'b1; c_addr = in_chan; chan_d = in_chan;
          pad_d = '0;   st_d   = ST_DATA;
        end else begin
          pad_d = pad_q - 1'b1;
          if (pad_q == PW'(1)) st_d = ST_HEAD;
        end
      end
      default: st_d = ST_HEAD;
    endcase
  end

  // State registers, advanced only on an accepted output word
  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      st_q   <= ST_HEAD;
      pad_q  <= '0;
      odd_q  <= 1'b0;
      chan_q <= '0;
    end else if (beat) begin
      st_q   <= st_d;
      pad_q  <= pad_d;
      odd_q  <= odd_d;
      chan_q <= chan_d;
    end
  end

  bf_sop_gap #(.SOP_GAP(SOP_GAP)) u_gap (
    .clk(clk), .rst_n(run_n), .beat(beat),
    .sop_beat(beat & c_sop), .gap_ok(gap_ok));

  bf_pad_track #(.LITE_WORDS(LITE_WORDS)) u_pad (
    .clk(clk), .rst_n(run_n), .data_beat(beat & ~c_ctl),
    .sop_beat(beat & c_sop), .mode_full(mode_full), .pad_req(pad_req));

  assign ctl_body = {1'b1, c_eops, c_sop, c_addr};

  bf_dip_gen u_dip (
    .clk(clk), .rst_n(run_n), .beat(beat), .is_ctl(c_ctl),
    .data_word(in_data), .ctl_body(ctl_body), .dip(dip));

  assign out_ctl  = c_ctl;
  assign out_word = c_ctl ? {ctl_body, dip} : in_data;
  assign in_ready = beat & c_take;

  // R1: an input beat is only taken together with a payload word
  p_take_r1: assert property (@(posedge clk) disable iff (!run_n)
    in_ready |-> (out_valid && !out_ctl && in_valid));
  // R10: no input is taken while downstream stalls
  p_ready_r10: assert property (@(posedge clk) disable iff (!run_n)
    !out_ready |-> !in_ready);
  // R10: framing state holds across a stalled cycle
  p_hold_r10: assert property (@(posedge clk) disable iff (!run_n)
    (out_valid && !out_ready) |=> ($stable(st_q) && $stable(pad_q)));
  // R4: a padding state always owes at least one word
  p_pad_nz_r4: assert property (@(posedge clk) disable iff (!run_n)
    (st_q == ST_PAD) |-> (pad_q != '0));
  // R11: no valid output while reset is asserted
  always_comb begin
    if (!rst_n) p_rst_quiet_r11: assert (!out_valid);
  end
endmodule

// File: tb/burst_framer_tb.sv
module burst_framer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPKT       = 14;
  localparam int LW         = 8;
  localparam int WATCHDOG   = 20000;

  // len[31:24] chan[23:16] full[15] gap[14:11] stall[10:7] bp[6]
  localparam logic [31:0] TBL [NPKT] = '{
    {8'd1,  8'h11, 1'b0, 4'd0, 4'd0, 1'b0, 6'd0},
    {8'd2,  8'h22, 1'b0, 4'd0, 4'd0, 1'b0, 6'd0},
    {8'd16, 8'h33, 1'b0, 4'd0, 4'd0, 1'b0, 6'd0},
    {8'd17, 8'h34, 1'b0, 4'd0, 4'd0, 1'b1, 6'd0},
    {8'd5,  8'h45, 1'b1, 4'd0, 4'd0, 1'b0, 6'd0},
    {8'd8,  8'h46, 1'b1, 4'd0, 4'd0, 1'b0, 6'd0},
    {8'd4,  8'h47, 1'b1, 4'd0, 4'd0, 1'b0, 6'd0},
    {8'd3,  8'h48, 1'b1, 4'd0, 4'd0, 1'b0, 6'd0},
    {8'd30, 8'h59, 1'b1, 4'd0, 4'd3, 1'b0, 6'd0},
    {8'd9,  8'h5A, 1'b0, 4'd2, 4'd2, 1'b0, 6'd0},
    {8'd40, 8'h6B, 1'b1, 4'd0, 4'd0, 1'b1, 6'd0},
    {8'd12, 8'h6C, 1'b1, 4'd0, 4'd0, 1'b1, 6'd0},
    {8'd7,  8'h7D, 1'b0, 4'd5, 4'd0, 1'b1, 6'd0},
    {8'd2,  8'h7E, 1'b1, 4'd0, 4'd0, 1'b0, 6'd0}
  };

  logic clk, rst_n, mode_full, in_valid, in_ready, in_last, in_odd;
  logic out_valid, out_ready, out_ctl;
  logic [15:0] in_data, out_word;
  logic [7:0]  in_chan;

  burst_framer dut_i (
    .clk(clk), .rst_n(rst_n), .mode_full(mode_full),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_odd(in_odd), .in_chan(in_chan),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_ctl(out_ctl));

  int n_chk = 0, n_bad = 0;
  int eops_seen = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input int p, input int i);
    return 8'((p * 29 + i * 7 + 3) & 255);
  endfunction

  function automatic logic [3:0] fold(input logic [15:0] x);
    return x[15:12] ^ x[11:8] ^ x[7:4] ^ x[3:0];
  endfunction

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Downstream stall pattern
  logic [7:0] lfsr;
  bit bp_on = 0;
  initial begin
    out_ready = 1'b1;
    lfsr = 8'h5B;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = bp_on ? lfsr[0] : 1'b1;
    end
  end

  // Output monitor state
  logic [7:0]  got [64];
  logic [15:0] dacc = 16'h0;
  bit in_pkt_m = 0, paused_m = 0, after_eop = 0, have_sop = 0, last_full = 0;
  int nbytes = 0, wcnt = 0, pk = 0, kcnt = 0, pad_need = 0, last_w = 0;
  int beat_idx = 0, last_sop = 0, cont_seen = 0, merges = 0;
  logic [7:0] cur_chan = 8'h0;

  task automatic handle_beat(input logic [15:0] w, input logic c);
    logic [31:0] e;
    logic [1:0]  es;
    logic [7:0]  addr;
    bit sop, merged, ok;
    int len, blen;
    if (!c) begin
      check(in_pkt_m, "R1", "payload word outside packet", 0, 1);
      check(!paused_m, "R9", "payload resumed without continuation", 1, 0);
      if (nbytes < 62) begin
        got[nbytes] = w[15:8];
        got[nbytes+1] = w[7:0];
      end
      nbytes += 2;
      wcnt++;
      dacc ^= w;
    end else begin
      es = w[14:13]; sop = w[12]; addr = w[11:4]; merged = 0;
      check(w[15], "R2", "control type bit", w[15], 1);
      check(w[3:0] == fold(dacc ^ {w[15:4], 4'hF}), "R7", "parity nibble",
            w[3:0], fold(dacc ^ {w[15:4], 4'hF}));
      dacc = 16'h0;
      if (es != 2'b00) begin
        e = TBL[pk < NPKT ? pk : 0];
        len = int'(e[31:24]);
        check(in_pkt_m, "R6", "end word outside packet", 0, 1);
        check(es == ((len % 2) ? 2'b11 : 2'b10), "R6", "end status", es,
              (len % 2) ? 3 : 2);
        blen = 2 * wcnt - ((es == 2'b11) ? 1 : 0);
        check(blen == len, "R6", "packet length", blen, len);
        ok = 1;
        for (int i = 0; i < len && i < 62; i++)
          if (got[i] != pbyte(pk, i)) ok = 0;
        check(ok, "R1", "payload bytes", pk, pk);
        after_eop = 1; kcnt = 0;
        last_full = e[15]; last_w = wcnt;
        pad_need = e[15] ? (wcnt % 2) : ((LW - (wcnt % LW)) % LW);
        in_pkt_m = 0; paused_m = 0;
        pk++; eops_seen++;
        if (sop) merged = 1;
      end
      if (sop) begin
        if (have_sop)
          check(beat_idx - last_sop >= 8, "R3", "start spacing",
                beat_idx - last_sop, 8);
        have_sop = 1; last_sop = beat_idx;
        if (after_eop) begin
          if (last_full) begin
            if (merged) begin
              check(last_w % 2 == 0, "R5", "merge with odd word count", last_w, 0);
              merges++;
            end
          end else begin
            check(!merged, "R4", "merged word in lite mode", 1, 0);
            check(kcnt >= pad_need, "R4", "lite pad idles", kcnt, pad_need);
          end
          after_eop = 0;
        end
        e = TBL[pk < NPKT ? pk : 0];
        check(addr == e[23:16], "R2", "start channel", addr, e[23:16]);
        cur_chan = addr; in_pkt_m = 1; nbytes = 0; wcnt = 0;
      end else if (es == 2'b00) begin
        if (addr != 8'h0) begin
          check(in_pkt_m && paused_m, "R9", "stray continuation", 0, 1);
          check(addr == cur_chan, "R9", "continuation channel", addr, cur_chan);
          paused_m = 0; cont_seen++;
        end else begin
          if (in_pkt_m) paused_m = 1;
          if (after_eop) kcnt++;
        end
      end
    end
    beat_idx++;
  endtask

  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && out_valid) begin
        if (!out_ready)
          check(!in_ready, "R10", "in_ready during stall", in_ready, 0);
        else
          handle_beat(out_word, out_ctl);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", eops_seen, NPKT);
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  // Stimulus: reset, then walk the table, then end checks
  initial begin
    logic [31:0] e;
    int len, nb;
    rst_n = 1'b0; mode_full = 1'b0; in_valid = 1'b0; in_data = '0;
    in_last = 1'b0; in_odd = 1'b0; in_chan = '0;
    repeat (3) @(negedge clk);
    #2 check(!out_valid, "R11", "out_valid in reset", out_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check(out_valid, "R11", "out_valid after release", out_valid, 1);
    check(out_ctl && out_word == 16'h8007, "R8", "idle word after reset",
          out_word, 16'h8007);

    for (int k = 0; k < NPKT; k++) begin
      e = TBL[k];
      len = int'(e[31:24]);
      nb = (len + 1) / 2;
      if (e[15] != mode_full) begin
        @(negedge clk); in_valid = 1'b0;
        wait (eops_seen == k);
        bp_on = 0;
        repeat (10) @(negedge clk);
        mode_full = e[15];
      end
      bp_on = e[6];
      if (e[14:11] != 0) begin
        @(negedge clk); in_valid = 1'b0;
        repeat (int'(e[14:11]) - 1) @(negedge clk);
      end
      for (int b = 0; b < nb; b++) begin
        if (e[10:7] != 0 && b == int'(e[10:7])) begin
          @(negedge clk); in_valid = 1'b0;
          repeat (3) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_chan  = e[23:16];
        in_last  = (b == nb - 1);
        in_odd   = (b == nb - 1) && (len % 2 == 1);
        in_data  = {pbyte(k, 2*b), (2*b + 1 < len) ? pbyte(k, 2*b + 1) : 8'h00};
        #1;
        while (!in_ready) begin
          @(negedge clk); #1;
        end
      end
    end
    @(negedge clk); in_valid = 1'b0;
    bp_on = 0;
    wait (eops_seen == NPKT);
    repeat (12) @(negedge clk);
    #2;
    check(out_ctl && out_word == 16'h8007, "R8", "idle when input empty",
          out_word, 16'h8007);
    check(pk == NPKT, "R1", "packets delivered", pk, NPKT);
    check(cont_seen == 2, "R9", "continuation words", cont_seen, 2);
    check(merges > 0, "R5", "merged end/start words", merges, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule